// File: doc/BRIEF.md
# VLIW Packet Issue Sequencer

This block walks through the instructions of one very-long-instruction-word packet. Starting at the current program counter it requests 32-bit instruction words one at a time, clears general register 0 for one cycle ahead of each instruction, and offers the word to an external execute stage tagged with first and last markers. The execute stage returns the address of the following instruction and the functional-unit slot it used. The sequencer remembers the most recent floating-point/media slot of the packet.

A packet closes when an issued word has its top bit set, or when the configured maximum number of instructions has gone out, whichever comes first. The sequencer then asks the write-back/interrupt stage to commit. It adds the packet length to a running retired-instruction total and opens the next packet only after the commit is acknowledged. Opening a packet emits an initialisation pulse, used outside to clear the write queue and the exception flags, and latches the packet's start address.

Top module: `vliw_issue_seq`

## Requirements
- R1: A fetched word whose bit 31 is 1 is issued with `iss_last`=1, and after its issue handshake the next request is `commit_valid`, not a fetch.
- R2: When no word carries the marker, the MAX_INSNS-th instruction is issued with `iss_last`=1 and the packet closes after it.
- R3: `iss_first` is 1 for the first instruction of each packet and 0 for every later one.
- R4: `gr0_we` is high for exactly the one cycle between a fetch handshake and the cycle in which `iss_valid` rises.
- R5: At each issue handshake, an `exec_slot` code of 4 to 7 (FM0 to FM3) sets `fm_valid`=1 and `fm_idx`=code-4 from the next cycle. Codes 0 to 3 leave both unchanged. The packet initialisation pulse clears `fm_valid`.
- R6: The first fetch after reset uses RESET_PC. Each later fetch address equals the `exec_next_pc` taken at the previous issue handshake, including across packet boundaries.
- R7: After a packet closes, `commit_valid` stays high with `commit_len` equal to the number of instructions issued, and no fetch starts until `commit_ready` is accepted.
- R8: `retired` is 0 after reset and grows by the packet length in the cycle after each commit handshake.
- R9: `pkt_init` pulses for one cycle right after reset and after each commit handshake. From the next cycle on, `prev_pc` holds the start address of the packet that is opening.
- R10: While `fetch_valid`, `iss_valid` or `commit_valid` is high without its ready, it stays high and its address or payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | output | 1 | Instruction word requested |
| fetch_addr | output | AW | Address of requested word |
| fetch_ready | input | 1 | Word supplied on fetch_data this cycle |
| fetch_data | input | 32 | Instruction word; bit 31 marks packet end |
| gr0_we | output | 1 | Write zero to general register 0 |
| iss_valid | output | 1 | Instruction offered to execute |
| iss_word | output | 32 | Instruction word offered |
| iss_pc | output | AW | Address of offered instruction |
| iss_first | output | 1 | First instruction of packet |
| iss_last | output | 1 | Last instruction of packet |
| iss_ready | input | 1 | Execute accepts instruction |
| exec_next_pc | input | AW | Next address from execute, valid with iss_ready |
| exec_slot | input | SLOT_W | Unit slot used, valid with iss_ready; 4..7 are FM0..FM3 |
| pkt_init | output | 1 | Packet initialisation pulse |
| prev_pc | output | AW | Start address of current packet |
| fm_valid | output | 1 | A media slot was used in this packet |
| fm_idx | output | 2 | Most recent media slot index |
| commit_valid | output | 1 | Write-back and interrupt check requested |
| commit_len | output | CW | Instructions in the closing packet |
| commit_ready | input | 1 | Commit done |
| retired | output | RW | Retired instruction total |

## Verification
Once the packet counter goes wrong, it shows at the next issue as a wrong `iss_first` or `iss_last`, and at commit as a wrong `commit_len`. A stale program counter appears on `fetch_addr` in the first fetch cycle after the issue handshake that should have loaded it. A media-slot record that is not cleared shows on `fm_valid` in the first fetch cycle of the next packet. A lost retired update shows one cycle after the commit handshake. The bench checks each of these at the earliest cycle in which it can be seen.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int IW     = 32;
  localparam int SLOT_W = 3;
  typedef enum logic [2:0] {
    S_INIT, S_FETCH, S_ZERO, S_ISSUE, S_COMMIT
  } seq_state_e;
endpackage

// File: rtl/vis_counters.sv
module vis_counters #(
  parameter int MAX_INSNS = 4,
  parameter int CW = 3,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pkt_clr,
  input  logic          pkt_inc,
  input  logic          commit_fire,
  output logic [CW-1:0] pkt_cnt,
  output logic [RW-1:0] retired
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_cnt <= '0;
      retired <= '0;
    end else begin
      if (pkt_clr)      pkt_cnt <= '0;
      else if (pkt_inc) pkt_cnt <= pkt_cnt + 1'b1;
      if (commit_fire)  retired <= retired + RW'(pkt_cnt);
    end
  end

  a_r2_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    pkt_cnt <= CW'(MAX_INSNS));
  a_r8_retired_grows: assert property (@(posedge clk) disable iff (rst)
    commit_fire |=> retired == $past(retired) + RW'($past(pkt_cnt)));
endmodule

// File: rtl/vis_media_track.sv
module vis_media_track
  import vis_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [SLOT_W-1:0] slot,
  output logic              fm_valid,
  output logic [1:0]        fm_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fm_valid <= 1'b0;
      fm_idx   <= '0;
    end else if (clr) begin
      fm_valid <= 1'b0;
    end else if (upd && slot[2]) begin
      fm_valid <= 1'b1;
      fm_idx   <= slot[1:0];
    end
  end

  a_r5_clear_on_init: assert property (@(posedge clk) disable iff (rst)
    clr |=> !fm_valid);
  a_r5_non_media_keeps: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(upd && slot[2])) |=> $stable(fm_valid) && $stable(fm_idx));
endmodule

// File: rtl/vliw_issue_seq.sv
module vliw_issue_seq
  import vis_pkg::*;
#(
  parameter int          MAX_INSNS = 4,
  parameter int          AW        = 32,
  parameter int          RW        = 32,
  parameter logic [31:0] RESET_PC  = 32'h0000_1000,
  localparam int         CW        = $clog2(MAX_INSNS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              fetch_valid,
  output logic [AW-1:0]     fetch_addr,
  input  logic              fetch_ready,
  input  logic [31:0]       fetch_data,
  output logic              gr0_we,
  output logic              iss_valid,
  output logic [31:0]       iss_word,
  output logic [AW-1:0]     iss_pc,
  output logic              iss_first,
  output logic              iss_last,
  input  logic              iss_ready,
  input  logic [AW-1:0]     exec_next_pc,
  input  logic [SLOT_W-1:0] exec_slot,
  output logic              pkt_init,
  output logic [AW-1:0]     prev_pc,
  output logic              fm_valid,
  output logic [1:0]        fm_idx,
  output logic              commit_valid,
  output logic [CW-1:0]     commit_len,
  input  logic              commit_ready,
  output logic [RW-1:0]     retired
);
  seq_state_e    st;
  logic [AW-1:0] pc;
  logic [IW-1:0] word;
  logic [CW-1:0] pkt_cnt;
  logic          last_now;
  logic          iss_fire;
  logic          commit_fire;

  assign last_now    = word[IW-1] || (pkt_cnt == CW'(MAX_INSNS - 1));
  assign iss_fire    = (st == S_ISSUE) && iss_ready;
  assign commit_fire = (st == S_COMMIT) && commit_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_INIT;
      pc      <= AW'(RESET_PC);
      word    <= '0;
      prev_pc <= '0;
    end else begin
      unique case (st)
        S_INIT: begin
          prev_pc <= pc;
          st      <= S_FETCH;
        end
        S_FETCH: if (fetch_ready) begin
          word <= fetch_data;
          st   <= S_ZERO;
        end
        S_ZERO: st <= S_ISSUE;
        S_ISSUE: if (iss_ready) begin
          pc <= exec_next_pc;
          st <= last_now ? S_COMMIT : S_FETCH;
        end
        S_COMMIT: if (commit_ready) st <= S_INIT;
        default: st <= S_INIT;
      endcase
    end
  end

  assign pkt_init     = (st == S_INIT);
  assign fetch_valid  = (st == S_FETCH);
  assign fetch_addr   = pc;
  assign gr0_we       = (st == S_ZERO);
  assign iss_valid    = (st == S_ISSUE);
  assign iss_word     = word;
  assign iss_pc       = pc;
  assign iss_first    = (pkt_cnt == '0);
  assign iss_last     = last_now;
  assign commit_valid = (st == S_COMMIT);
  assign commit_len   = pkt_cnt;

  vis_counters #(.MAX_INSNS(MAX_INSNS), .CW(CW), .RW(RW)) u_cnt (
    .clk(clk), .rst(rst), .pkt_clr(pkt_init), .pkt_inc(iss_fire),
    .commit_fire(commit_fire), .pkt_cnt(pkt_cnt), .retired(retired)
  );

  vis_media_track u_fm (
    .clk(clk), .rst(rst), .clr(pkt_init), .upd(iss_fire),
    .slot(exec_slot), .fm_valid(fm_valid), .fm_idx(fm_idx)
  );

  a_r1_last_to_commit: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && iss_last) |=> commit_valid);
  a_r3_first_once: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |=> !iss_first);
  a_r4_zero_before_issue: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_valid) |-> $past(gr0_we));
  a_r7_commit_holds: assert property (@(posedge clk) disable iff (rst)
    (commit_valid && !commit_ready) |=> commit_valid && $stable(commit_len));
  a_r10_fetch_holds: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_ready) |=> fetch_valid && $stable(fetch_addr));
  a_r10_issue_holds: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> iss_valid && $stable(iss_word));
  a_r10_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pkt_init, fetch_valid, gr0_we, iss_valid, commit_valid}));
endmodule

// File: tb/vliw_issue_seq_bench.sv
module vliw_issue_seq_bench;
  localparam int MAXI = 4;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        fetch_valid, fetch_ready, gr0_we, iss_valid, iss_first, iss_last, iss_ready;
  logic [31:0] fetch_addr, fetch_data, iss_word, iss_pc, exec_next_pc, prev_pc;
  logic [2:0]  exec_slot, commit_len;
  logic        pkt_init, fm_valid, commit_valid, commit_ready;
  logic [1:0]  fm_idx;
  logic [31:0] retired;

  vliw_issue_seq #(.MAX_INSNS(MAXI), .RESET_PC(RPC)) u_vliw_issue_seq (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data), .gr0_we(gr0_we),
    .iss_valid(iss_valid), .iss_word(iss_word), .iss_pc(iss_pc),
    .iss_first(iss_first), .iss_last(iss_last), .iss_ready(iss_ready),
    .exec_next_pc(exec_next_pc), .exec_slot(exec_slot), .pkt_init(pkt_init),
    .prev_pc(prev_pc), .fm_valid(fm_valid), .fm_idx(fm_idx),
    .commit_valid(commit_valid), .commit_len(commit_len),
    .commit_ready(commit_ready), .retired(retired)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] word_of(input logic [31:0] a, input bit m);
    return {m, 31'(a * 5 + 7)};
  endfunction

  initial begin
    logic [31:0] pc, pstart, nxt;
    bit          fmv;
    logic [1:0]  fmi;
    int          n, stall;
    bit          saw_init, lst;
    logic [31:0] tot;
    fetch_ready = 0; iss_ready = 0; commit_ready = 0;
    fetch_data = 0; exec_next_pc = 0; exec_slot = 0;
    repeat (3) @(negedge clk);
    chk(!fetch_valid && !iss_valid && !commit_valid, "R9 reset idle", fetch_valid, 0);
    chk(retired == 0, "R8 reset retired", retired, 0);
    chk(fm_valid == 0, "R5 reset fm", fm_valid, 0);
    rst = 0;
    pc = RPC; tot = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int lp = 0; lp <= MAXI; lp++) begin
        pstart = pc; fmv = 0; fmi = 0; n = 0; saw_init = 0;
        for (int i = 0; i < MAXI; i++) begin
          stall = (pass == 0) ? 0 : (lp + i) % 3;
          while (!fetch_valid) begin
            if (pkt_init) saw_init = 1;
            @(negedge clk);
          end
          if (i == 0) begin
            chk(saw_init, "R9 init pulse", saw_init, 1);
            chk(prev_pc == pstart, "R9 prev_pc", prev_pc, pstart);
            chk(fm_valid == 0, "R5 cleared at packet start", fm_valid, 0);
          end
          chk(fetch_addr == pc, "R6 fetch addr", fetch_addr, pc);
          for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(fetch_valid && fetch_addr == pc, "R10 fetch hold", fetch_addr, pc);
          end
          lst = (i == lp);
          fetch_data = word_of(pc, lst);
          fetch_ready = 1;
          @(negedge clk);
          fetch_ready = 0;
          chk(gr0_we && !iss_valid, "R4 gr0 pulse", gr0_we, 1);
          @(negedge clk);
          chk(iss_valid && !gr0_we, "R4 issue follows", iss_valid, 1);
          chk(iss_word == word_of(pc, lst) && iss_pc == pc, "R10 issue payload", iss_word, word_of(pc, lst));
          chk(iss_first == (i == 0), "R3 first flag", iss_first, i == 0);
          if (lp == MAXI)
            chk(iss_last == (i == MAXI - 1), "R2 cap last", iss_last, i == MAXI - 1);
          else
            chk(iss_last == lst, "R1 marker last", iss_last, lst);
          for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(iss_valid && iss_word == word_of(pc, lst), "R10 issue hold", iss_word, word_of(pc, lst));
          end
          nxt = ((lp + pass + i) % 3 == 1) ? pc + 32'h100 : pc + 4;
          exec_next_pc = nxt;
          exec_slot = 3'((lp * 3 + pass * 5 + i) % 8);
          iss_ready = 1;
          @(negedge clk);
          iss_ready = 0;
          if (exec_slot[2]) begin fmv = 1; fmi = exec_slot[1:0]; end
          chk(fm_valid == fmv && (!fmv || fm_idx == fmi), "R5 media slot", {fm_valid, fm_idx}, {fmv, fmi});
          pc = nxt; n++;
          if (i == lp || i == MAXI - 1) begin
            chk(commit_valid && !fetch_valid, (lp == MAXI) ? "R2 closes" : "R1 closes", commit_valid, 1);
            break;
          end
        end
        chk(commit_len == 3'(n), "R7 commit len", commit_len, n);
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          chk(commit_valid && !fetch_valid, "R7 waits commit", commit_valid, 1);
        end
        commit_ready = 1;
        @(negedge clk);
        commit_ready = 0;
        tot = tot + n;
        chk(retired == tot, "R8 retired", retired, tot);
        chk(pkt_init, "R9 init after commit", pkt_init, 1);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule